// File: doc/BRIEF.md
# Four-Phase Bus Cycle Sequencer

This block paces every instruction cycle of a small processor through four consecutive phases: execute, arbitrate/hold, fetch and latch. It runs on a clock at twice the processor rate, so each cycle of `clk` is one half-clock of the processor, and phase lengths are counted in these half-clock steps. The execute, fetch and latch phases normally take a single half-clock each. The hold phase grows when the instruction needs more time, and it also waits on operand-bus arbitration. The latch phase grows for instructions that carry extra memory traffic.

Decode presents four instruction-class flags while the execute phase is running, and the block captures them on that phase's only edge. From the current phase, the half-clock index within it and the captured class, the block drives several outputs: the execute/fetch status line, the read and write enables of the instruction port, the operand-bus enable and grant acknowledge, the operand data strobe, and the enable of the primary instruction latch. The datapath and decode around it are not part of the block.

Top module: `quad_phase_seq`

## Requirements
- R1: After reset, `phase_o` reads 0 (execute). Phases then always advance in the order 0 (execute), 1 (hold), 2 (fetch), 3 (latch), and return to 0.
- R2: The execute phase (0) and the fetch phase (2) each last exactly one `clk` cycle.
- R3: Without arbitration delay, the hold phase (1) lasts 1 cycle. It lasts 3 cycles when the captured class has store-indirect, load-indirect or operand-access set.
- R4: The hold phase can end only on an edge where `arb_busy_i`=1 and `arb_grant_i`=0. Any other combination extends it by a further cycle. The hold length is therefore the larger of its R3 minimum and the index of the first ready half plus one.
- R5: The latch phase (3) lasts 1 cycle, or 3 cycles when the captured class has store-indirect, load-indirect, long-immediate or operand-access set.
- R6: The class flags are captured only on the edge that ends the execute phase. Changing them during phases 1 to 3 has no effect on that instruction.
- R7: `exec_n_fetch_o` is 0 in phases 0 and 1 and is 1 in phases 2 and 3.
- R8: In phases 2 and 3, a store-indirect instruction drives `ip_we_o`=1 and `ip_oe_o`=0, and any other instruction drives `ip_oe_o`=1 and `ip_we_o`=0. In phases 0 and 1 both are 0, so the two are never high together.
- R9: `opb_en_o` and `opb_gack_o` are 1 exactly during phases 2 and 3 of an operand-access instruction.
- R10: `opb_ds_o` is 1 during an operand-access instruction from two cycles (one processor clock) after the fetch phase begins until the latch phase ends. With a stretched latch phase, that is its second and third cycles.
- R11: `pir_le_o` is 1 in every cycle of phase 3 and in no other phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; one cycle is one half-clock of the processor |
| rst | input | 1 | Synchronous active-high reset |
| cls_st_ind_i | input | 1 | Class flag: store-indirect |
| cls_ld_ind_i | input | 1 | Class flag: load-indirect |
| cls_long_imm_i | input | 1 | Class flag: long-immediate operand |
| cls_op_acc_i | input | 1 | Class flag: operand-port access |
| arb_busy_i | input | 1 | Arbitration input; must be 1 for the hold phase to end |
| arb_grant_i | input | 1 | Arbitration input; must be 0 for the hold phase to end |
| phase_o | output | 2 | Current phase code: 0 execute, 1 hold, 2 fetch, 3 latch |
| exec_n_fetch_o | output | 1 | Status: 0 while executing, 1 while fetching |
| ip_oe_o | output | 1 | Instruction-port read enable |
| ip_we_o | output | 1 | Instruction-port write enable |
| opb_en_o | output | 1 | Operand address/data bus enable |
| opb_gack_o | output | 1 | Operand bus grant acknowledge |
| opb_ds_o | output | 1 | Operand data strobe |
| pir_le_o | output | 1 | Primary instruction latch enable |

## Verification
The arbitration property assumes that `arb_busy_i` and `arb_grant_i` are stable around each rising edge, so the value seen at an edge is the one that decides whether the hold phase ends. The bench only changes these inputs, and the class flags, on falling edges. It programs the first ready hold half explicitly, and during not-ready halves it picks randomly among the three combinations that keep the phase waiting. This lets the expected hold length be computed exactly. The class flags are re-randomized after the execute phase, which makes each instruction's behaviour depend only on the values captured on its one sampling edge.

// File: rtl/qps_pkg.sv
package qps_pkg;

    typedef enum logic [1:0] {
        PH_EXEC  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_FETCH = 2'd2,
        PH_LATCH = 2'd3
    } phase_e;

    typedef struct packed {
        logic st_ind;
        logic ld_ind;
        logic long_imm;
        logic op_acc;
    } iclass_t;

    typedef struct packed {
        logic stat;
        logic oe;
        logic we;
        logic opb;
        logic gack;
        logic ds;
        logic le;
    } ctl_t;

    // Hold phase needs its long form for indirect memory work or operand traffic.
    function automatic logic hold_is_long(iclass_t c);
        return c.st_ind | c.ld_ind | c.op_acc;
    endfunction

    // Latch phase additionally stretches for a trailing immediate word.
    function automatic logic latch_is_long(iclass_t c);
        return c.st_ind | c.ld_ind | c.long_imm | c.op_acc;
    endfunction

    function automatic logic in_fetch_half(phase_e p);
        return (p == PH_FETCH) || (p == PH_LATCH);
    endfunction

endpackage

// File: rtl/qps_class_latch.sv
module qps_class_latch
    import qps_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_e  phase,
    input  iclass_t cls_in,
    output iclass_t cls_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= '0;
        end else if (phase == PH_EXEC) begin
            cls_q <= cls_in;
        end
    end

endmodule

// File: rtl/qps_phase_fsm.sv
module qps_phase_fsm
    import qps_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int HOLD_LONG = 3,
    parameter int LATCH_LONG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  iclass_t          cls,
    input  logic             arb_ready,
    output phase_e           phase,
    output logic [CNT_W-1:0] idx
);

    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_LONG - 1);
    localparam logic [CNT_W-1:0] LATCH_LAST = CNT_W'(LATCH_LONG - 1);
    localparam logic [CNT_W-1:0] IDX_MAX    = {CNT_W{1'b1}};

    logic [CNT_W-1:0] hold_need;
    logic [CNT_W-1:0] latch_need;
    logic             leave;
    phase_e           phase_nx;

    always_comb begin
        hold_need  = hold_is_long(cls)  ? HOLD_LAST  : '0;
        latch_need = latch_is_long(cls) ? LATCH_LAST : '0;
        unique case (phase)
            PH_EXEC:  leave = 1'b1;
            PH_HOLD:  leave = (idx >= hold_need) && arb_ready;
            PH_FETCH: leave = 1'b1;
            PH_LATCH: leave = (idx >= latch_need);
            default:  leave = 1'b1;
        endcase
        phase_nx = phase_e'(phase + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_EXEC;
            idx   <= '0;
        end else if (leave) begin
            phase <= phase_nx;
            idx   <= '0;
        end else if (idx != IDX_MAX) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/qps_out_decode.sv
module qps_out_decode
    import qps_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DS_LAG = 2
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] idx,
    input  iclass_t          cls,
    output ctl_t             ctl
);

    // The fetch phase is one half long, so the strobe lag maps to a latch-phase index.
    localparam logic [CNT_W-1:0] DS_IDX = CNT_W'(DS_LAG - 1);

    logic fetching;

    always_comb begin
        fetching = in_fetch_half(phase);
        ctl.stat = fetching;
        ctl.oe   = fetching & ~cls.st_ind;
        ctl.we   = fetching &  cls.st_ind;
        ctl.opb  = fetching &  cls.op_acc;
        ctl.gack = fetching &  cls.op_acc;
        ctl.ds   = (phase == PH_LATCH) && (idx >= DS_IDX) && cls.op_acc;
        ctl.le   = (phase == PH_LATCH);
    end

endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
    import qps_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int HOLD_LONG  = 3,
    parameter int LATCH_LONG = 3,
    parameter int DS_LAG     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cls_st_ind_i,
    input  logic       cls_ld_ind_i,
    input  logic       cls_long_imm_i,
    input  logic       cls_op_acc_i,
    input  logic       arb_busy_i,
    input  logic       arb_grant_i,
    output logic [1:0] phase_o,
    output logic       exec_n_fetch_o,
    output logic       ip_oe_o,
    output logic       ip_we_o,
    output logic       opb_en_o,
    output logic       opb_gack_o,
    output logic       opb_ds_o,
    output logic       pir_le_o
);

    iclass_t          cls_in;
    iclass_t          cls_q;
    phase_e           phase;
    logic [CNT_W-1:0] idx;
    ctl_t             ctl;
    logic             arb_ready;

    assign cls_in = '{st_ind: cls_st_ind_i, ld_ind: cls_ld_ind_i,
                      long_imm: cls_long_imm_i, op_acc: cls_op_acc_i};
    assign arb_ready = arb_busy_i & ~arb_grant_i;

    qps_class_latch u_cls (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .cls_in (cls_in),
        .cls_q  (cls_q)
    );

    qps_phase_fsm #(
        .CNT_W      (CNT_W),
        .HOLD_LONG  (HOLD_LONG),
        .LATCH_LONG (LATCH_LONG)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cls       (cls_q),
        .arb_ready (arb_ready),
        .phase     (phase),
        .idx       (idx)
    );

    qps_out_decode #(
        .CNT_W  (CNT_W),
        .DS_LAG (DS_LAG)
    ) u_dec (
        .phase (phase),
        .idx   (idx),
        .cls   (cls_q),
        .ctl   (ctl)
    );

    assign phase_o        = phase;
    assign exec_n_fetch_o = ctl.stat;
    assign ip_oe_o        = ctl.oe;
    assign ip_we_o        = ctl.we;
    assign opb_en_o       = ctl.opb;
    assign opb_gack_o     = ctl.gack;
    assign opb_ds_o       = ctl.ds;
    assign pir_le_o       = ctl.le;

endmodule

// File: rtl/quad_phase_seq_chk.sv
module quad_phase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase_o,
    input logic       exec_n_fetch_o,
    input logic       ip_oe_o,
    input logic       ip_we_o,
    input logic       opb_en_o,
    input logic       opb_gack_o,
    input logic       opb_ds_o,
    input logic       pir_le_o,
    input logic       arb_busy_i,
    input logic       arb_grant_i
);

    AST_EXEC_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        phase_o == 2'd0 |=> phase_o == 2'd1); // R1
    AST_FETCH_TO_LATCH: assert property (@(posedge clk) disable iff (rst)
        phase_o == 2'd2 |=> phase_o == 2'd3); // R2
    AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1 && !(arb_busy_i && !arb_grant_i)) |=> phase_o == 2'd1); // R4
    AST_STATUS_PHASE: assert property (@(posedge clk) disable iff (rst)
        exec_n_fetch_o == phase_o[1]); // R7
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ip_oe_o && ip_we_o)); // R8
    AST_OPB_PAIR: assert property (@(posedge clk) disable iff (rst)
        opb_en_o == opb_gack_o); // R9
    AST_DS_INSIDE: assert property (@(posedge clk) disable iff (rst)
        opb_ds_o |-> (opb_en_o && pir_le_o)); // R10
    AST_DS_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(opb_ds_o) |-> $past(phase_o) == 2'd3); // R10
    AST_LE_LATCH: assert property (@(posedge clk) disable iff (rst)
        pir_le_o == (phase_o == 2'd3)); // R11

endmodule

bind quad_phase_seq quad_phase_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .phase_o        (phase_o),
    .exec_n_fetch_o (exec_n_fetch_o),
    .ip_oe_o        (ip_oe_o),
    .ip_we_o        (ip_we_o),
    .opb_en_o       (opb_en_o),
    .opb_gack_o     (opb_gack_o),
    .opb_ds_o       (opb_ds_o),
    .pir_le_o       (pir_le_o),
    .arb_busy_i     (arb_busy_i),
    .arb_grant_i    (arb_grant_i)
);

// File: tb/quad_phase_seq_tb_top.sv
`timescale 1ns/1ps
module quad_phase_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       st_ind = 1'b0, ld_ind = 1'b0, long_imm = 1'b0, op_acc = 1'b0;
    logic       busy = 1'b1, grant = 1'b0;
    logic [1:0] phase_o;
    logic       stat, oe, we, opb, gack, ds, le;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    quad_phase_seq dut_i (
        .clk            (clk),
        .rst            (rst),
        .cls_st_ind_i   (st_ind),
        .cls_ld_ind_i   (ld_ind),
        .cls_long_imm_i (long_imm),
        .cls_op_acc_i   (op_acc),
        .arb_busy_i     (busy),
        .arb_grant_i    (grant),
        .phase_o        (phase_o),
        .exec_n_fetch_o (stat),
        .ip_oe_o        (oe),
        .ip_we_o        (we),
        .opb_en_o       (opb),
        .opb_gack_o     (gack),
        .opb_ds_o       (ds),
        .pir_le_o       (le)
    );

    // f = {st_ind, ld_ind, long_imm, op_acc}
    function automatic logic [6:0] exp_ctl(int p, int i, logic [3:0] f);
        logic fe;
        fe = (p >= 2);
        return {fe, fe & ~f[3], fe & f[3], fe & f[0], fe & f[0],
                (p == 3) && (i >= 1) && f[0], p == 3};
    endfunction

    function automatic int exp_hold(logic [3:0] f, int w);
        int m;
        m = (f[3] | f[2] | f[0]) ? 3 : 1;
        return (w + 1 > m) ? w + 1 : m;
    endfunction

    function automatic int exp_latch(logic [3:0] f);
        return (f != 4'd0) ? 3 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_arb(input bit rdy);
        int r;
        if (rdy) begin
            busy = 1'b1; grant = 1'b0;
        end else begin
            r = $urandom % 3;
            busy  = (r == 2);
            grant = (r != 0);
        end
    endtask

    task automatic check_outs(input int p, input int i, input logic [3:0] f);
        logic [6:0] a, e;
        a = {stat, oe, we, opb, gack, ds, le};
        e = exp_ctl(p, i, f);
        check(a == e, "R7/R8/R9/R10/R11 outputs", int'(a), int'(e));
    endtask

    // Called at a falling edge while phase_o is 0.
    task automatic run_instr(input logic [3:0] f, input int w);
        int len [4];
        int p, prev, i, guard;
        bit order_ok;
        check(phase_o == 2'd0, "R1 instruction starts in phase 0", int'(phase_o), 0);
        {st_ind, ld_ind, long_imm, op_acc} = f;
        set_arb($urandom % 2);
        len = '{1, 0, 0, 0};
        check_outs(0, 0, f);
        prev = 0; order_ok = 1; guard = 0;
        forever begin
            @(negedge clk);
            p = int'(phase_o);
            guard++;
            if ((p == 0 && prev != 0) || guard > 40) break;
            if (p != prev && p != prev + 1) order_ok = 0;
            i = len[p];
            len[p]++;
            check_outs(p, i, f);
            // R6: disturb class flags once they should be captured
            {st_ind, ld_ind, long_imm, op_acc} = 4'($urandom);
            if (p == 1) set_arb(i >= w);
            else set_arb($urandom % 2);
            prev = p;
        end
        check(order_ok && guard <= 40, "R1 phase order", prev, 3);
        check(len[0] == 1, "R2 execute length", len[0], 1);
        check(len[2] == 1, "R2 fetch length", len[2], 1);
        check(len[1] == exp_hold(f, w), "R3/R4/R6 hold length", len[1], exp_hold(f, w));
        check(len[3] == exp_latch(f), "R5/R6 latch length", len[3], exp_latch(f));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(phase_o == 2'd0, "R1 reset phase", int'(phase_o), 0);
        check({stat, oe, we, opb, gack, ds, le} == 7'd0, "R1 reset outputs",
              int'({stat, oe, we, opb, gack, ds, le}), 0);
        // Directed: every class combination, no arbitration wait
        for (int c = 0; c < 16; c++) run_instr(4'(c), 0);
        // Directed arbitration corners (R4)
        run_instr(4'b0000, 2);
        run_instr(4'b1000, 1);
        run_instr(4'b0001, 7);
        run_instr(4'b0010, 9);
        run_instr(4'b0100, 3);
        // Random mix
        for (int k = 0; k < 300; k++) run_instr(4'($urandom), $urandom % 6);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule